// File: doc/BRIEF.md
# Transmit FIFO Start-Threshold and Flush Controller

This block decides when a transmit FIFO may start handing buffered frame data to the MAC transmitter, and runs a self-clearing flush of that FIFO. In threshold mode, transmission may start once the head frame's buffered byte count goes past a level chosen by a 3-bit code. The code table is not linear: four codes give large multiples of 64 bytes and four give small levels from 40 down to 16 bytes. A complete frame that is already buffered always qualifies to start. In store-and-forward mode, only a complete frame qualifies and the threshold code has no effect.

A flush command drives a one-cycle reset pulse to the FIFO storage and raises a busy flag. The busy flag clears by itself only when the FIFO holds no bytes, holds no complete frames, and the host has accepted every transmit status still pending. The block counts pending statuses internally from push and acknowledge strobes. A frame the MAC has already taken is not recalled: the MAC finishes it as an underflowed runt, outside this block.

Configuration writes are ignored while a flush is busy. A change to the store-and-forward setting written while the transmit process runs is held back and applied on the first cycle the process is stopped.

Top module: `tx_fifo_start_ctl`

## Requirements
- R1: The threshold code `cfg_thr_i` is decoded as 0→64, 1→128, 2→192, 3→256, 4→40, 5→32, 6→24, 7→16 bytes.
- R2: With store-and-forward off and no complete frame held, `tx_start_o` is 1 exactly when `fill_level_i` is strictly greater than the decoded threshold.
- R3: When `full_frames_i` is nonzero, `tx_start_o` is 1 regardless of the fill level and the mode, unless a flush is busy.
- R4: With store-and-forward on and `full_frames_i` zero, `tx_start_o` is 0 for any fill level.
- R5: A write with `cfg_flush_i`=1 while not busy makes `fifo_rst_o` high for exactly the one cycle after the write edge, and sets `flush_busy_o` from that same cycle.
- R6: `flush_busy_o` falls only after a cycle in which `fill_level_i`, `full_frames_i` and the pending-status count are all zero. It stays high while any of them is nonzero.
- R7: The pending-status count rises on `sts_push_i` and falls on `sts_ack_i`. An acknowledge with nothing pending is ignored.
- R8: While `flush_busy_o` is 1, configuration writes change neither the threshold nor the mode, and do not start a new flush.
- R9: A store-and-forward change written while `tx_running_i` is 1 is held back. It takes effect at the first clock edge where `tx_running_i` is 0.
- R10: `tx_start_o` is 0 whenever `flush_busy_o` is 1.
- R11: After reset the threshold code is 0 (64 bytes), store-and-forward is off, `flush_busy_o` is 0 and `fifo_rst_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sf_i | input | 1 | Store-and-forward enable (write data) |
| cfg_thr_i | input | 3 | Threshold code (write data) |
| cfg_flush_i | input | 1 | Flush command (write data) |
| tx_running_i | input | 1 | Transmit process is running |
| fill_level_i | input | LVL_W | Bytes held in the FIFO |
| full_frames_i | input | FRM_W | Complete frames held in the FIFO |
| sts_push_i | input | 1 | A transmit status became pending |
| sts_ack_i | input | 1 | Host accepted one transmit status |
| tx_start_o | output | 1 | Transmitter may start or continue reading |
| fifo_rst_o | output | 1 | One-cycle FIFO reset pulse |
| flush_busy_o | output | 1 | Flush in progress (self-clearing) |

## Verification
The embedded assertions check on every cycle that start is masked during a flush, that a store-and-forward configuration never starts without a complete frame, that the reset pulse is single-cycle and lies inside the busy window, that busy falls only from an empty, fully acknowledged state, that the pending count does not wrap below zero, and that the mode register never changes while the transmitter runs. The bench scenarios are needed for the rest: the exact threshold table boundary for each code, whether a write during a flush was really dropped, and the moment a deferred mode change finally lands.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

  localparam int unsigned THR_W = 3;
  localparam int unsigned THB_W = 9;

  // non-linear threshold table: codes 0..3 large, 4..7 small
  function automatic logic [THB_W-1:0] thr_bytes(input logic [THR_W-1:0] code);
    logic [THB_W-1:0] b;
    if (!code[2]) b = THB_W'((int'(code[1:0]) + 1) * 64);
    else          b = THB_W'(40 - int'(code[1:0]) * 8);
    return b;
  endfunction

  typedef struct packed {
    logic             sf;
    logic [THR_W-1:0] thr;
  } tfc_cfg_t;

endpackage

// File: rtl/tfc_cfg.sv
module tfc_cfg
  import tfc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sf_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             flush_i,
  input  logic             busy_i,
  input  logic             run_i,
  output tfc_cfg_t         cfg_o,
  output logic             flush_go_o
);

  tfc_cfg_t cfg_q;
  logic     hold_v_q, hold_sf_q;
  logic     wr_ok;

  assign wr_ok      = we_i && !busy_i;
  assign flush_go_o = wr_ok && flush_i;
  assign cfg_o      = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      hold_v_q  <= 1'b0;
      hold_sf_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        cfg_q.thr <= thr_i;
        if (!run_i) begin
          cfg_q.sf <= sf_i;
          hold_v_q <= 1'b0;
        end else begin
          hold_v_q  <= 1'b1;
          hold_sf_q <= sf_i;
        end
      end else if (hold_v_q && !run_i) begin
        cfg_q.sf <= hold_sf_q;
        hold_v_q <= 1'b0;
      end
    end
  end

  // R9
  sf_frozen_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i) |-> $stable(cfg_q.sf));

  // R8
  cfg_hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> $stable(cfg_q.thr));

endmodule

// File: rtl/tfc_start.sv
module tfc_start
  import tfc_pkg::*;
#(
  parameter int unsigned LVL_W     = 12,
  parameter int unsigned FRM_W     = 4,
  parameter bit          START_REG = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tfc_cfg_t         cfg_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [FRM_W-1:0] frames_i,
  input  logic             busy_i,
  output logic             start_o
);

  localparam int unsigned CMP_W = (LVL_W > THB_W) ? LVL_W : THB_W;

  logic [CMP_W-1:0] lvl_x, thr_x;
  logic             have_frame, over_thr, start_d;

  assign lvl_x      = CMP_W'(level_i);
  assign thr_x      = CMP_W'(thr_bytes(cfg_i.thr));
  assign have_frame = |frames_i;
  assign over_thr   = !cfg_i.sf && (lvl_x > thr_x);
  assign start_d    = !busy_i && (have_frame || over_thr);

  generate
    if (START_REG) begin : g_reg
      logic start_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) start_q <= 1'b0;
        else         start_q <= start_d;
      end
      assign start_o = start_q;
    end else begin : g_comb
      assign start_o = start_d;
    end
  endgenerate

  // R4
  sf_needs_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!START_REG && cfg_i.sf && frames_i == '0) |-> !start_o);

endmodule

// File: rtl/tfc_flush.sv
module tfc_flush #(
  parameter int unsigned LVL_W = 12,
  parameter int unsigned FRM_W = 4,
  parameter int unsigned STS_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [FRM_W-1:0] frames_i,
  input  logic             push_i,
  input  logic             ack_i,
  output logic             fifo_rst_o,
  output logic             busy_o
);

  localparam logic [STS_W-1:0] PEND_MAX = {STS_W{1'b1}};

  logic [STS_W-1:0] pend_q;
  logic             busy_q, rst_q, drained;
  logic             inc, dec;

  assign inc     = push_i && (pend_q != PEND_MAX);
  assign dec     = ack_i && (pend_q != '0);
  assign drained = (level_i == '0) && (frames_i == '0) && (pend_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (inc && !dec) begin
      pend_q <= pend_q + 1'b1;
    end else if (dec && !inc) begin
      pend_q <= pend_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= go_i;
      if (go_i)                 busy_q <= 1'b1;
      else if (busy_q && drained && !rst_q) busy_q <= 1'b0;
    end
  end

  assign fifo_rst_o = rst_q;
  assign busy_o     = busy_q;

  // R5
  rst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_o |=> !fifo_rst_o);

  // R5
  rst_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_o |-> busy_o);

  // R6
  busy_fall_drained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(level_i == '0 && frames_i == '0 && pend_q == '0));

  // R7
  pend_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == '0 && ack_i && !push_i) |=> pend_q == '0);

endmodule

// File: rtl/tx_fifo_start_ctl.sv
module tx_fifo_start_ctl
  import tfc_pkg::*;
#(
  parameter int unsigned LVL_W     = 12,
  parameter int unsigned FRM_W     = 4,
  parameter int unsigned STS_W     = 4,
  parameter bit          START_REG = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_sf_i,
  input  logic [2:0]       cfg_thr_i,
  input  logic             cfg_flush_i,
  input  logic             tx_running_i,
  input  logic [LVL_W-1:0] fill_level_i,
  input  logic [FRM_W-1:0] full_frames_i,
  input  logic             sts_push_i,
  input  logic             sts_ack_i,
  output logic             tx_start_o,
  output logic             fifo_rst_o,
  output logic             flush_busy_o
);

  tfc_cfg_t cfg;
  logic     flush_go;
  logic     busy;

  tfc_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .sf_i       (cfg_sf_i),
    .thr_i      (cfg_thr_i),
    .flush_i    (cfg_flush_i),
    .busy_i     (busy),
    .run_i      (tx_running_i),
    .cfg_o      (cfg),
    .flush_go_o (flush_go)
  );

  tfc_flush #(.LVL_W(LVL_W), .FRM_W(FRM_W), .STS_W(STS_W)) u_flush (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (flush_go),
    .level_i    (fill_level_i),
    .frames_i   (full_frames_i),
    .push_i     (sts_push_i),
    .ack_i      (sts_ack_i),
    .fifo_rst_o (fifo_rst_o),
    .busy_o     (busy)
  );

  tfc_start #(.LVL_W(LVL_W), .FRM_W(FRM_W), .START_REG(START_REG)) u_start (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_i    (cfg),
    .level_i  (fill_level_i),
    .frames_i (full_frames_i),
    .busy_i   (busy),
    .start_o  (tx_start_o)
  );

  assign flush_busy_o = busy;

  // R10
  no_start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!START_REG && flush_busy_o) |-> !tx_start_o);

endmodule

// File: tb/sim_tx_fifo_start_ctl.sv
module sim_tx_fifo_start_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 0, sf = 0, fl = 0, run = 0, push = 0, ack = 0;
  logic [2:0]  thr = 0;
  logic [11:0] lvl = 0;
  logic [3:0]  frm = 0;
  logic        start, frst, busy;
  int          n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  tx_fifo_start_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_sf_i(sf), .cfg_thr_i(thr),
    .cfg_flush_i(fl), .tx_running_i(run), .fill_level_i(lvl), .full_frames_i(frm),
    .sts_push_i(push), .sts_ack_i(ack), .tx_start_o(start), .fifo_rst_o(frst),
    .flush_busy_o(busy)
  );

  typedef struct packed {
    logic        sf;
    logic [2:0]  thr;
    logic [11:0] lvl;
    logic [3:0]  frm;
    logic        exp;
  } vec_t;

  // R1 R2 boundaries per code, then R3/R4 cases
  localparam vec_t VECS [19] = '{
    '{1'b0, 3'd0, 12'd64,  4'd0, 1'b0}, '{1'b0, 3'd0, 12'd65,  4'd0, 1'b1},
    '{1'b0, 3'd1, 12'd128, 4'd0, 1'b0}, '{1'b0, 3'd1, 12'd129, 4'd0, 1'b1},
    '{1'b0, 3'd2, 12'd192, 4'd0, 1'b0}, '{1'b0, 3'd2, 12'd193, 4'd0, 1'b1},
    '{1'b0, 3'd3, 12'd256, 4'd0, 1'b0}, '{1'b0, 3'd3, 12'd257, 4'd0, 1'b1},
    '{1'b0, 3'd4, 12'd40,  4'd0, 1'b0}, '{1'b0, 3'd4, 12'd41,  4'd0, 1'b1},
    '{1'b0, 3'd5, 12'd32,  4'd0, 1'b0}, '{1'b0, 3'd5, 12'd33,  4'd0, 1'b1},
    '{1'b0, 3'd6, 12'd24,  4'd0, 1'b0}, '{1'b0, 3'd6, 12'd25,  4'd0, 1'b1},
    '{1'b0, 3'd7, 12'd16,  4'd0, 1'b0}, '{1'b0, 3'd7, 12'd17,  4'd0, 1'b1},
    '{1'b0, 3'd3, 12'd10,  4'd1, 1'b1},
    '{1'b1, 3'd7, 12'd4000,4'd0, 1'b0},
    '{1'b1, 3'd7, 12'd5,   4'd1, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [2:0] t, input logic f);
    we = 1; sf = s; thr = t; fl = f;
    tick();
    we = 0; fl = 0;
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (2) tick();
    // R11 reset state
    lvl = 64; #1;
    chk("R11 start", start, 1'b0);
    chk("R11 busy", busy, 1'b0);
    chk("R11 rst", frst, 1'b0);
    lvl = 65; #1;
    chk("R11 thr64", start, 1'b1);
    rst_n = 1; tick();

    foreach (VECS[i]) begin
      wr(VECS[i].sf, VECS[i].thr, 1'b0);
      lvl = VECS[i].lvl; frm = VECS[i].frm; #1;
      chk("R1 R2 R3 R4 vec", start, VECS[i].exp);
    end

    // R5 R6 R7 R8 R10 flush
    wr(1'b0, 3'd0, 1'b0);
    lvl = 100; frm = 2;
    push = 1; tick(); tick(); push = 0;
    wr(1'b0, 3'd0, 1'b1);
    #1;
    chk("R5 pulse", frst, 1'b1);
    chk("R5 busy", busy, 1'b1);
    chk("R10 masked", start, 1'b0);
    wr(1'b1, 3'd7, 1'b1);          // R8 ignored write
    #1;
    chk("R5 single", frst, 1'b0);
    lvl = 0; frm = 0;
    tick(); #1;
    chk("R6 pending", busy, 1'b1);
    ack = 1; tick(); #1;
    chk("R6 one left", busy, 1'b1);
    tick(); ack = 0; #1;
    chk("R6 drained wait", busy, 1'b1);
    tick(); #1;
    chk("R6 cleared", busy, 1'b0);
    chk("R8 no reflush", frst, 1'b0);
    lvl = 20; #1;
    chk("R8 thr kept", start, 1'b0);
    frm = 1; #1;
    chk("R8 sf kept", start, 1'b1);
    frm = 0; lvl = 0;

    // R7 ack with nothing pending ignored
    ack = 1; tick(); ack = 0;
    push = 1; tick(); push = 0;
    wr(1'b0, 3'd0, 1'b1);
    tick(); tick(); #1;
    chk("R7 no underflow", busy, 1'b1);
    ack = 1; tick(); ack = 0;
    tick(); #1;
    chk("R7 acked", busy, 1'b0);

    // R9 deferred mode change
    run = 1;
    wr(1'b1, 3'd0, 1'b0);
    lvl = 100; #1;
    chk("R9 held", start, 1'b1);
    tick(); #1;
    chk("R9 still held", start, 1'b1);
    run = 0; tick(); #1;
    chk("R9 applied", start, 1'b0);
    run = 1; tick(); #1;
    chk("R9 stays", start, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule